// File: doc/BRIEF.md
# Instruction Fetch and Effective Address Sequencer

This block is the control front end of a small 16-bit accumulator machine that keeps program and data in one memory. It runs a multi-cycle loop over a synchronous single-port memory. Each pass copies the program counter into the memory address register and reads the instruction word. The word is moved into the instruction register, the program counter steps by one, and the sequencer then forms the effective address from the 8-bit address field held in the low byte of the instruction. It hands that address, with the instruction, to an execute stage over a valid/ready handshake.

Two instruction bits choose how the address is formed. The field is used as-is, or it has the index register value added to it. In either case the result can also serve as a pointer: a second memory read is made there, and the low byte of the word read becomes the final address. One opcode class skips the address phase. While the execute stage holds the handshake, it can read or write memory at the effective address through the sequencer. When it accepts an instruction it can flag a taken branch, which loads the program counter from the effective address.

A single adder serves both the program counter increment and the index addition, so every address computation wraps modulo 256.

Top module: `fetch_addr_seq`

## Requirements
- R1: After reset the sequencer makes no memory access and holds `ex_valid_o` low until `start_i` is seen high; the first fetch then reads address 0.
- R2: Each instruction is fetched with a single one-cycle read strobe at the program counter, and the word read appears unchanged on `ex_ir_o`.
- R3: Without a taken branch, the next fetch address is the previous one plus 1, wrapping from 0xFF to 0x00.
- R4: Mode bits IR[9:8] = 00 (direct): `ex_addr_o` equals IR[7:0], with no operand read.
- R5: Mode 01 (indexed): `ex_addr_o` equals (IR[7:0] + `index_i`) mod 256, with no operand read.
- R6: Mode 10 (indirect): one extra read is made at IR[7:0], and `ex_addr_o` equals bits [7:0] of the word read.
- R7: Mode 11 (index-indirect): the extra read is made at (IR[7:0] + `index_i`) mod 256, and `ex_addr_o` equals bits [7:0] of the word read.
- R8: Opcode IR[15:12] = 0xF has no address phase. Its mode bits are ignored, no operand read is made, and `ex_addr_o` equals IR[7:0].
- R9: While `ex_valid_o` is high and `ex_ready_i` is low, `ex_valid_o`, `ex_ir_o` and `ex_addr_o` hold and no fetch read is issued. A cycle with both high ends the hand-off.
- R10: Accepting an instruction with `ex_branch_i` high makes the next fetch read at the instruction's effective address.
- R11: Memory writes occur only while `ex_valid_o` is high, driven by `ex_wr_i` with `ex_wdata_i` at `ex_addr_o`; `ex_rd_i` in that window reads at `ex_addr_o` with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Leaves the idle state after reset |
| mem_addr_o | output | 8 | Memory address |
| mem_rd_o | output | 1 | Memory read strobe; data valid the next cycle |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data |
| index_i | input | 8 | Current index register value |
| ex_valid_o | output | 1 | Instruction and effective address offered to execute |
| ex_ready_i | input | 1 | Execute accepts the offered instruction |
| ex_branch_i | input | 1 | With `ex_ready_i`, loads the program counter from the effective address |
| ex_rd_i | input | 1 | Execute-stage read request at the effective address |
| ex_wr_i | input | 1 | Execute-stage write request at the effective address |
| ex_wdata_i | input | 16 | Execute-stage write data |
| ex_ir_o | output | 16 | Instruction register |
| ex_addr_o | output | 8 | Effective address |

## Verification
The properties assume that the memory answers a read strobe with data in the following cycle. They also assume that `ex_branch_i` matters only together with `ex_ready_i`, and that `index_i` is stable from instruction issue until the address is formed. The stimulus keeps within these limits. The bench memory is a registered read array. The execute responder changes the index only in the accept cycle. It raises `ex_rd_i` for one cycle well before accepting, and it asserts `ex_wr_i` only during the hand-off, so sequencer fetch reads and execute accesses never overlap.

// File: rtl/fas_pkg.sv
package fas_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_FETCH_MAR,
    S_FETCH_RD,
    S_FETCH_CAP,
    S_IR_LOAD,
    S_EA_FORM,
    S_PTR_RD,
    S_PTR_CAP,
    S_PTR_MAR,
    S_EXEC
  } seq_state_e;

  typedef struct packed {
    logic ld_mar_pc;
    logic ld_mar_ea;
    logic ld_mar_mbr;
    logic ld_mbr;
    logic ld_ir;
    logic inc_pc;
    logic use_idx;
  } dp_ctl_t;

endpackage

// File: rtl/fas_adder.sv
module fas_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o
);
  // carry out dropped: address arithmetic wraps
  assign sum_o = a_i + b_i;
endmodule

// File: rtl/fas_ctrl.sv
module fas_ctrl
  import fas_pkg::*;
#(
  parameter int          OPC_W      = 4,
  parameter logic [3:0]  NOADDR_OPC = 4'hF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [OPC_W-1:0] opc_i,
  input  logic [1:0]       mode_i,
  input  logic             ex_ready_i,
  output dp_ctl_t          dp_ctl_o,
  output logic             rd_o,
  output logic             exec_o
);

  seq_state_e state_q, state_d;
  logic       no_addr;

  assign no_addr = (opc_i == NOADDR_OPC[OPC_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:      if (start_i) state_d = S_FETCH_MAR;
      S_FETCH_MAR: state_d = S_FETCH_RD;
      S_FETCH_RD:  state_d = S_FETCH_CAP;
      S_FETCH_CAP: state_d = S_IR_LOAD;
      S_IR_LOAD:   state_d = S_EA_FORM;
      S_EA_FORM:   state_d = (!no_addr && mode_i[1]) ? S_PTR_RD : S_EXEC;
      S_PTR_RD:    state_d = S_PTR_CAP;
      S_PTR_CAP:   state_d = S_PTR_MAR;
      S_PTR_MAR:   state_d = S_EXEC;
      S_EXEC:      if (ex_ready_i) state_d = S_FETCH_MAR;
      default:     state_d = S_IDLE;
    endcase
  end

  always_comb begin
    dp_ctl_o            = '0;
    dp_ctl_o.ld_mar_pc  = (state_q == S_FETCH_MAR);
    dp_ctl_o.ld_mbr     = (state_q == S_FETCH_CAP) || (state_q == S_PTR_CAP);
    dp_ctl_o.ld_ir      = (state_q == S_IR_LOAD);
    dp_ctl_o.inc_pc     = (state_q == S_IR_LOAD);
    dp_ctl_o.ld_mar_ea  = (state_q == S_EA_FORM);
    dp_ctl_o.use_idx    = (state_q == S_EA_FORM) && !no_addr && mode_i[0];
    dp_ctl_o.ld_mar_mbr = (state_q == S_PTR_MAR);
    rd_o                = (state_q == S_FETCH_RD) || (state_q == S_PTR_RD);
    exec_o              = (state_q == S_EXEC);
  end

endmodule

// File: rtl/fas_datapath.sv
module fas_datapath
  import fas_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  dp_ctl_t           ctl_i,
  input  logic              br_load_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic [ADDR_W-1:0] index_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] mar_o,
  output logic [DATA_W-1:0] ir_o
);

  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [DATA_W-1:0] mbr_q, ir_q;
  logic [ADDR_W-1:0] add_a, add_b, add_sum;

  // one adder: PC step in IR_LOAD, field + index in EA_FORM
  assign add_a = ctl_i.inc_pc ? pc_q : ir_q[ADDR_W-1:0];
  assign add_b = ctl_i.inc_pc ? ADDR_W'(1) : (ctl_i.use_idx ? index_i : '0);

  fas_adder #(.W(ADDR_W)) u_adder (
    .a_i   (add_a),
    .b_i   (add_b),
    .sum_o (add_sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      mar_q <= '0;
      mbr_q <= '0;
      ir_q  <= '0;
    end else begin
      if (br_load_i)         pc_q <= mar_q;
      else if (ctl_i.inc_pc) pc_q <= add_sum;

      if (ctl_i.ld_mar_pc)       mar_q <= pc_q;
      else if (ctl_i.ld_mar_ea)  mar_q <= add_sum;
      else if (ctl_i.ld_mar_mbr) mar_q <= mbr_q[ADDR_W-1:0];

      if (ctl_i.ld_mbr) mbr_q <= mem_rdata_i;
      if (ctl_i.ld_ir)  ir_q  <= mbr_q;
    end
  end

  assign pc_o  = pc_q;
  assign mar_o = mar_q;
  assign ir_o  = ir_q;

endmodule

// File: rtl/fetch_addr_seq.sv
module fetch_addr_seq
  import fas_pkg::*;
#(
  parameter int         DATA_W     = 16,
  parameter int         ADDR_W     = 8,
  parameter int         MODE_LSB   = 8,
  parameter int         OPC_W      = 4,
  parameter logic [3:0] NOADDR_OPC = 4'hF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic [ADDR_W-1:0] index_i,
  output logic              ex_valid_o,
  input  logic              ex_ready_i,
  input  logic              ex_branch_i,
  input  logic              ex_rd_i,
  input  logic              ex_wr_i,
  input  logic [DATA_W-1:0] ex_wdata_i,
  output logic [DATA_W-1:0] ex_ir_o,
  output logic [ADDR_W-1:0] ex_addr_o
);

  localparam int OPC_LSB = DATA_W - OPC_W;

  dp_ctl_t           dp_ctl;
  logic              seq_rd, exec;
  logic [ADDR_W-1:0] pc_w, mar_w;
  logic [DATA_W-1:0] ir_w;

  fas_ctrl #(
    .OPC_W      (OPC_W),
    .NOADDR_OPC (NOADDR_OPC)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .opc_i      (ir_w[OPC_LSB +: OPC_W]),
    .mode_i     (ir_w[MODE_LSB +: 2]),
    .ex_ready_i (ex_ready_i),
    .dp_ctl_o   (dp_ctl),
    .rd_o       (seq_rd),
    .exec_o     (exec)
  );

  fas_datapath #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctl_i       (dp_ctl),
    .br_load_i   (exec && ex_ready_i && ex_branch_i),
    .mem_rdata_i (mem_rdata_i),
    .index_i     (index_i),
    .pc_o        (pc_w),
    .mar_o       (mar_w),
    .ir_o        (ir_w)
  );

  // MAR always addresses memory; execute shares it during the hand-off
  assign mem_addr_o  = mar_w;
  assign mem_rd_o    = seq_rd || (exec && ex_rd_i);
  assign mem_wr_o    = exec && ex_wr_i;
  assign mem_wdata_o = ex_wdata_i;
  assign ex_valid_o  = exec;
  assign ex_ir_o     = ir_w;
  assign ex_addr_o   = mar_w;

endmodule

// File: rtl/fas_seq_chk.sv
module fas_seq_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_rd_o,
  input logic              mem_wr_o,
  input logic              ex_valid_o,
  input logic              ex_ready_i,
  input logic              ex_branch_i,
  input logic [DATA_W-1:0] ex_ir_o,
  input logic [ADDR_W-1:0] ex_addr_o,
  input logic [ADDR_W-1:0] pc_i
);

  // R11
  wr_in_exec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> ex_valid_o);

  // R9
  hold_offer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ex_valid_o && !ex_ready_i |=> ex_valid_o && $stable(ex_ir_o) && $stable(ex_addr_o));

  // R9
  accept_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ex_valid_o && ex_ready_i |=> !ex_valid_o);

  // R10
  branch_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ex_valid_o && ex_ready_i && ex_branch_i |=> pc_i == $past(ex_addr_o));

  // R3
  no_branch_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ex_valid_o && ex_ready_i && !ex_branch_i |=> pc_i == $past(pc_i));

  // R2
  single_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o && !ex_valid_o |=> !mem_rd_o);

endmodule

bind fetch_addr_seq fas_seq_chk #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_seq_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_rd_o    (mem_rd_o),
  .mem_wr_o    (mem_wr_o),
  .ex_valid_o  (ex_valid_o),
  .ex_ready_i  (ex_ready_i),
  .ex_branch_i (ex_branch_i),
  .ex_ir_o     (ex_ir_o),
  .ex_addr_o   (ex_addr_o),
  .pc_i        (pc_w)
);

// File: tb/tb_fetch_addr_seq.sv
`timescale 1ns/1ps
module tb_fetch_addr_seq;

  localparam int N_INSTR = 14;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  mem_addr_o;
  logic        mem_rd_o, mem_wr_o;
  logic [15:0] mem_wdata_o;
  logic [15:0] mem_rdata_i = '0;
  logic [7:0]  index_i = '0;
  logic        ex_valid_o;
  logic        ex_ready_i = 1'b0, ex_branch_i = 1'b0, ex_rd_i = 1'b0, ex_wr_i = 1'b0;
  logic [15:0] ex_wdata_i = '0;
  logic [15:0] ex_ir_o;
  logic [7:0]  ex_addr_o;

  always #4 clk_i = ~clk_i;

  fetch_addr_seq dut (
    .clk_i, .rst_ni, .start_i,
    .mem_addr_o, .mem_rd_o, .mem_wr_o, .mem_wdata_o, .mem_rdata_i,
    .index_i,
    .ex_valid_o, .ex_ready_i, .ex_branch_i, .ex_rd_i, .ex_wr_i, .ex_wdata_i,
    .ex_ir_o, .ex_addr_o
  );

  // registered-read memory
  logic [15:0] mem [256];
  always @(posedge clk_i) begin
    if (mem_rd_o) mem_rdata_i <= mem[mem_addr_o];
    if (mem_wr_o) mem[mem_addr_o] <= mem_wdata_o;
  end

  typedef struct {
    logic [15:0] ir;
    logic [7:0]  addr;
    logic [7:0]  pc;
    int          reads;
    string       pc_req;
    string       mode_req;
  } exp_t;
  exp_t exp_q[$];

  int n_chk = 0, n_fail = 0, done = 0, cyc = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // driver: load program, walk it by the requirements, push expected items
  task automatic drive_program();
    logic [7:0] pc, idx, ea;
    string prev;
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    mem[8'h00] = 16'h4030; // idx <- 0x30
    mem[8'h01] = 16'h1045; // direct
    mem[8'h02] = 16'h1110; // indexed
    mem[8'h03] = 16'h11F0; // indexed, wraps
    mem[8'h04] = 16'h1280; // indirect
    mem[8'h05] = 16'h1351; // index-indirect
    mem[8'h06] = 16'hF312; // no address phase
    mem[8'h07] = 16'h20E0; // execute write
    mem[8'h08] = 16'h3080; // execute read
    mem[8'h09] = 16'h1820; // branch to 0x20
    mem[8'h20] = 16'h13D0; // index-indirect, wraps
    mem[8'h21] = 16'h1A82; // indirect branch
    mem[8'hFF] = 16'h1011; // pc wraps after this
    mem[8'h80] = 16'h1277;
    mem[8'h81] = 16'hBEEF;
    mem[8'h82] = 16'h00FF;
    pc = 8'h00; idx = 8'h00; prev = "R1";
    for (int n = 0; n < N_INSTR; n++) begin
      exp_t e;
      e.ir = mem[pc]; e.pc = pc; e.pc_req = prev;
      if (e.ir[15:12] == 4'hF) begin
        e.addr = e.ir[7:0]; e.reads = 1; e.mode_req = "R8";
      end else begin
        ea = e.ir[7:0] + (e.ir[8] ? idx : 8'h00);
        case (e.ir[9:8])
          2'b00: e.mode_req = "R4";
          2'b01: e.mode_req = "R5";
          2'b10: e.mode_req = "R6";
          default: e.mode_req = "R7";
        endcase
        if (e.ir[9]) begin e.addr = mem[ea][7:0]; e.reads = 2; end
        else         begin e.addr = ea;           e.reads = 1; end
      end
      if (e.ir[15:12] == 4'h4) idx = e.addr;
      if (e.ir[11]) begin pc = e.addr; prev = "R10"; end
      else          begin pc = pc + 8'h01; prev = "R3"; end
      exp_q.push_back(e);
    end
  endtask

  // monitor + execute responder, all on the falling edge
  exp_t        cur;
  bit          seen = 0;
  int          rd_cnt = 0, wcnt = 0;
  logic [7:0]  first_addr = '0;
  logic [15:0] hold_ir = '0, rd_exp = '0;
  logic [7:0]  hold_addr = '0;

  always @(negedge clk_i) begin
    if (rst_ni) begin
      cyc++;
      if (ex_ready_i) begin
        ex_ready_i = 0; ex_branch_i = 0; ex_wr_i = 0;
        seen = 0; rd_cnt = 0; done++;
      end else begin
        if (!ex_valid_o && mem_rd_o) begin
          if (rd_cnt == 0) first_addr = mem_addr_o;
          rd_cnt++;
        end
        if (mem_wr_o && !ex_valid_o) chk("R11", 1, 0);
        if (ex_valid_o && !seen && exp_q.size() > 0) begin
          cur = exp_q.pop_front();
          seen = 1;
          chk(cur.pc_req, 32'(first_addr), 32'(cur.pc));   // R1/R3/R10
          chk("R2", 32'(ex_ir_o), 32'(cur.ir));
          chk(cur.mode_req, 32'(ex_addr_o), 32'(cur.addr));
          chk(cur.mode_req, rd_cnt, cur.reads);
          hold_ir = ex_ir_o; hold_addr = ex_addr_o;
          wcnt = (done % 3) + 1;
          if (hold_ir[15:12] == 4'h3) begin
            ex_rd_i = 1; rd_exp = mem[ex_addr_o];
          end
        end else if (ex_valid_o && seen) begin
          chk("R9", 32'(ex_ir_o), 32'(hold_ir));
          chk("R9", 32'(ex_addr_o), 32'(hold_addr));
          if (mem_rd_o && !ex_rd_i) chk("R9", 1, 0);
          if (ex_rd_i) begin
            chk("R11", 32'(mem_rdata_i), 32'(rd_exp));
            ex_rd_i = 0;
          end
          wcnt--;
          if (wcnt == 0) begin
            ex_ready_i  = 1;
            ex_branch_i = hold_ir[11];
            if (hold_ir[15:12] == 4'h2) begin ex_wr_i = 1; ex_wdata_i = 16'h5A5A; end
            if (hold_ir[15:12] == 4'h4) index_i = hold_addr;
          end
        end else if (!ex_valid_o && seen) begin
          chk("R9", 1, 0);
        end
      end
    end
  end

  initial begin
    drive_program();
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    // R1: idle until start
    repeat (5) begin
      @(negedge clk_i);
      chk("R1", {29'd0, mem_rd_o, mem_wr_o, ex_valid_o}, 32'd0);
    end
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
    while (done < N_INSTR && cyc < 5000) @(negedge clk_i);
    if (cyc >= 5000) chk("watchdog", 0, 1);
    repeat (2) @(negedge clk_i);
    chk("R11", 32'(mem[8'hE0]), 32'h5A5A);
    chk("R2", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule